// File: doc/BRIEF.md
# Successive-Approximation Converter Control and Bus Interface

This block is the digital side of a 12-bit successive-approximation converter. It decodes a chip-enable/chip-select pair, a read/convert line, a byte-address line, an output-format line and a mode line. From these it decides when a conversion starts and when the result goes onto the data bus. During a conversion it drives a trial code to an external comparator, one bit per clock, and shows a busy flag. The comparator itself, the DAC, the reference and all analog timing lie outside the block.

A conversion is either a full 12-bit cycle or a short 8-bit cycle. The byte-address value captured at the start event picks the length. The result is left-justified, so a short cycle fills the upper eight bits and leaves the low four bits zero. At read time the result is presented in one of two ways:
- as a single 12-bit word, or
- as two 8-bit bytes chosen by the byte-address line, with per-bit output enables that model tri-state pins.

The host can pick between two start styles. In full-control mode, the read/convert line going low starts a conversion. In standalone mode, a falling edge on that line starts it.

Top module: `sar_ctl_top`

## Requirements
- R1: No conversion starts and no bus bit is enabled unless `en` is high and `sel_n` is low.
- R2: With `solo`=0, a cycle in which the access is valid and `rdcv` is low, following a cycle in which that was not so, starts a conversion. Holding `rdcv` low does not start another conversion. With `rdcv` high the access is a read.
- R3: With `solo`=1, a conversion starts only on a falling edge of `rdcv` during a valid access. Holding `rdcv` low after completion does not restart it.
- R4: `addr0` low at the start event gives a full cycle in which `busy` is high for 12 clocks. `addr0` high gives a short cycle in which `busy` is high for 8 clocks.
- R5: `busy` rises on the clock edge that takes the start and stays high until the last bit is decided.
- R6: Each trial keeps the tested bit when `cmp_ge` is 1 and clears it when `cmp_ge` is 0, working from bit 11 downward. For a comparator that reports input ≥ trial, a full result equals the input code and a short result equals the input with bits 3..0 cleared.
- R7: In a read with `wide`=1 and not busy, all 12 bits of `bus_oe` are 1 and `bus_out` carries the result.
- R8: In a read with `wide`=0 and `addr0`=0, bits 11..4 are enabled with result bits 11..4, and bits 3..0 are disabled.
- R9: In a read with `wide`=0 and `addr0`=1, bits 3..0 carry result bits 3..0, bits 7..4 are enabled and driven 0, and bits 11..8 are disabled.
- R10: While `busy` is high, no bus bit is enabled, in either mode.
- R11: A start request during a conversion is ignored, and later changes of `addr0` do not change the length of the running conversion.
- R12: Bus outputs are registered: the drive pattern follows the inputs sampled at the previous clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Chip enable, active high |
| sel_n | input | 1 | Chip select, active low |
| rdcv | input | 1 | Read (high) / convert (low) |
| addr0 | input | 1 | Cycle length at start, byte select at read |
| wide | input | 1 | 1: one 12-bit word, 0: two bytes |
| solo | input | 1 | 1: standalone edge start, 0: full-control |
| cmp_ge | input | 1 | Comparator: analog input ≥ trial code |
| trial | output | 12 | Trial code for the DAC |
| busy | output | 1 | High while converting |
| bus_out | output | 12 | Data bus value |
| bus_oe | output | 12 | Per-bit drive enable (0 = high impedance) |

## Verification
On every cycle, the assertions check the following:
- `busy` only rises after a start request made under a valid access;
- the latched cycle length stays fixed throughout a conversion;
- a finished short result has zero low bits;
- the bus is silent in the cycle after `busy` is seen;
- the enable pattern always has 0, 8 or 12 bits set, with a zero middle nibble in the low-byte format.

Only the bench's scenarios can show the things that depend on a modelled analog value or on a sequence of host actions. These are the correct result codes, the exact busy lengths, the ignored restarts and edge-versus-level start behaviour in the two modes, and the data in each bus format.

// File: rtl/sar_pkg.sv
package sar_pkg;
  typedef enum logic [1:0] {
    FMT_OFF  = 2'd0,
    FMT_WORD = 2'd1,
    FMT_HI   = 2'd2,
    FMT_LO   = 2'd3
  } bus_fmt_e;
endpackage

// File: rtl/sar_decode.sv
module sar_decode (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic sel_n,
  input  logic rdcv,
  input  logic solo,
  output logic start_o,
  output logic read_o
);
  logic access;
  logic creq;
  logic rdcv_q;
  logic creq_q;

  assign access = en & ~sel_n;
  assign creq   = access & ~rdcv;
  // full-control: start on entry into a convert access; standalone: falling rdcv
  assign start_o = solo ? (access & rdcv_q & ~rdcv) : (creq & ~creq_q);
  assign read_o  = access & rdcv;

  always_ff @(posedge clk) begin
    if (rst) begin
      rdcv_q <= 1'b0;
      creq_q <= 1'b1;
    end else begin
      rdcv_q <= rdcv;
      creq_q <= creq;
    end
  end
endmodule

// File: rtl/sar_engine.sv
module sar_engine #(
  parameter int W       = 12,
  parameter int SHORT_W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start_i,
  input  logic         a0_i,
  input  logic         cmp_ge_i,
  output logic [W-1:0] trial_o,
  output logic [W-1:0] res_o,
  output logic         busy_o
);
  localparam int IW   = $clog2(W);
  localparam int LO_W = W - SHORT_W;
  localparam logic [W-1:0]  MSB_ONE    = {1'b1, {(W-1){1'b0}}};
  localparam logic [W-1:0]  LSB_ONE    = {{(W-1){1'b0}}, 1'b1};
  localparam logic [IW-1:0] TOP_IDX    = IW'(W - 1);
  localparam logic [IW-1:0] SHORT_LAST = IW'(LO_W);

  logic          busy_q;
  logic          short_q;
  logic [IW-1:0] idx_q;
  logic [W-1:0]  sar_q;
  logic [W-1:0]  res_q;
  logic [W-1:0]  kept;
  logic [W-1:0]  nxt_one;
  logic [IW-1:0] last_idx;

  assign last_idx = short_q ? SHORT_LAST : '0;
  assign nxt_one  = LSB_ONE << (idx_q - IW'(1));

  always_comb begin
    kept = sar_q;
    if (!cmp_ge_i) kept[idx_q] = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q  <= 1'b0;
      short_q <= 1'b0;
      idx_q   <= '0;
      sar_q   <= '0;
      res_q   <= '0;
    end else if (!busy_q) begin
      if (start_i) begin
        busy_q  <= 1'b1;
        short_q <= a0_i;
        idx_q   <= TOP_IDX;
        sar_q   <= MSB_ONE;
      end
    end else if (idx_q == last_idx) begin
      busy_q <= 1'b0;
      sar_q  <= kept;
      res_q  <= kept;
    end else begin
      sar_q <= kept | nxt_one;
      idx_q <= idx_q - IW'(1);
    end
  end

  assign trial_o = sar_q;
  assign res_o   = res_q;
  assign busy_o  = busy_q;

  // R5: busy only rises after a start request
  a_r5_busy_from_start: assert property (@(posedge clk) disable iff (rst)
    $rose(busy_q) |-> $past(start_i));
  // R11: cycle length is frozen during a conversion
  a_r11_len_frozen: assert property (@(posedge clk) disable iff (rst)
    (busy_q && $past(busy_q)) |-> $stable(short_q));
  // R6: a finished short result has zero low bits
  a_r6_short_low_zero: assert property (@(posedge clk) disable iff (rst)
    (!busy_q && short_q) |-> (res_q[LO_W-1:0] == '0));
  // R4: the bit index never goes below the cycle's last bit
  a_r4_idx_floor: assert property (@(posedge clk) disable iff (rst)
    busy_q |-> (idx_q >= last_idx));
endmodule

// File: rtl/sar_bus_mux.sv
module sar_bus_mux
  import sar_pkg::*;
#(
  parameter int W    = 12,
  parameter int HI_W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         read_i,
  input  logic         busy_i,
  input  logic         wide_i,
  input  logic         a0_i,
  input  logic [W-1:0] res_i,
  output logic [W-1:0] out_o,
  output logic [W-1:0] oe_o
);
  localparam int LO_W = W - HI_W;

  bus_fmt_e     fmt;
  logic [W-1:0] d_n;
  logic [W-1:0] e_n;
  logic [W-1:0] out_q;
  logic [W-1:0] oe_q;

  always_comb begin
    if (!read_i || busy_i) fmt = FMT_OFF;
    else if (wide_i)       fmt = FMT_WORD;
    else if (a0_i)         fmt = FMT_LO;
    else                   fmt = FMT_HI;
  end

  for (genvar i = 0; i < W; i++) begin : g_bit
    localparam bit IN_LOW  = (i < LO_W);
    localparam bit IN_BYTE = (i < HI_W);
    always_comb begin
      case (fmt)
        FMT_WORD: begin e_n[i] = 1'b1;     d_n[i] = res_i[i]; end
        FMT_HI:   begin e_n[i] = !IN_LOW;  d_n[i] = IN_LOW ? 1'b0 : res_i[i]; end
        FMT_LO:   begin e_n[i] = IN_BYTE;  d_n[i] = IN_LOW ? res_i[i] : 1'b0; end
        default:  begin e_n[i] = 1'b0;     d_n[i] = 1'b0; end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_q <= '0;
      oe_q  <= '0;
    end else begin
      out_q <= d_n;
      oe_q  <= e_n;
    end
  end

  assign out_o = out_q;
  assign oe_o  = oe_q;

  // R10: no drive in the cycle after busy is seen
  a_r10_quiet_busy: assert property (@(posedge clk) disable iff (rst)
    busy_i |=> (oe_q == '0));
  // R7, R8, R9: enable pattern is empty, one byte, or the full word
  a_r7_oe_shape: assert property (@(posedge clk) disable iff (rst)
    ($countones(oe_q) == 0) || ($countones(oe_q) == HI_W) || ($countones(oe_q) == W));
  // R9: low-byte format drives a zero middle nibble
  a_r9_mid_zero: assert property (@(posedge clk) disable iff (rst)
    (oe_q[0] && !oe_q[W-1]) |-> (out_q[HI_W-1:LO_W] == '0));
endmodule

// File: rtl/sar_ctl_top.sv
module sar_ctl_top #(
  parameter int W       = 12,
  parameter int SHORT_W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  input  logic         sel_n,
  input  logic         rdcv,
  input  logic         addr0,
  input  logic         wide,
  input  logic         solo,
  input  logic         cmp_ge,
  output logic [W-1:0] trial,
  output logic         busy,
  output logic [W-1:0] bus_out,
  output logic [W-1:0] bus_oe
);
  logic         start;
  logic         rd;
  logic [W-1:0] res;

  sar_decode u_dec (
    .clk(clk), .rst(rst), .en(en), .sel_n(sel_n), .rdcv(rdcv), .solo(solo),
    .start_o(start), .read_o(rd)
  );

  sar_engine #(.W(W), .SHORT_W(SHORT_W)) u_eng (
    .clk(clk), .rst(rst), .start_i(start), .a0_i(addr0), .cmp_ge_i(cmp_ge),
    .trial_o(trial), .res_o(res), .busy_o(busy)
  );

  sar_bus_mux #(.W(W), .HI_W(SHORT_W)) u_mux (
    .clk(clk), .rst(rst), .read_i(rd), .busy_i(busy), .wide_i(wide), .a0_i(addr0),
    .res_i(res), .out_o(bus_out), .oe_o(bus_oe)
  );

  // R1: a conversion only begins under a valid access
  a_r1_access_gate: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(en && !sel_n));
endmodule

// File: tb/sim_sar_ctl_top.sv
module sim_sar_ctl_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        en = 1'b0, sel_n = 1'b1, rdcv = 1'b1, addr0 = 1'b0, wide = 1'b1, solo = 1'b0;
  logic [11:0] vin = '0;
  logic        cmp_ge;
  logic [11:0] trial, bus_out, bus_oe;
  logic        busy;
  int          n_chk = 0, n_bad = 0;

  always #2.5 clk = ~clk;
  assign cmp_ge = (vin >= trial);

  sar_ctl_top u0 (
    .clk(clk), .rst(rst), .en(en), .sel_n(sel_n), .rdcv(rdcv), .addr0(addr0),
    .wide(wide), .solo(solo), .cmp_ge(cmp_ge), .trial(trial), .busy(busy),
    .bus_out(bus_out), .bus_oe(bus_oe)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [23:0] exp_bus(input logic [11:0] r, input logic w, input logic a0);
    if (w)        return {r, 12'hFFF};
    else if (!a0) return {r & 12'hFF0, 12'hFF0};
    else          return {{8'h00, r[3:0]}, 12'h0FF};
  endfunction

  function automatic logic [11:0] exp_res(input logic [11:0] v, input logic shrt);
    return shrt ? (v & 12'hFF0) : v;
  endfunction

  task automatic do_read(input logic w, input logic a0, input logic [11:0] r, input string req);
    logic [23:0] e;
    en = 1'b1; sel_n = 1'b0; rdcv = 1'b1; wide = w; addr0 = a0;
    @(negedge clk);
    e = exp_bus(r, w, a0);
    chk({req, " oe"}, 32'(bus_oe), 32'(e[11:0]));
    chk({req, " data"}, 32'(bus_out & bus_oe), 32'(e[23:12]));
  endtask

  // starts and completes a conversion; disturb adds mid-run restarts and addr0 flips
  task automatic do_conv(input logic md, input logic a0, input logic [11:0] v, input bit disturb);
    int n;
    solo = md; en = 1'b1; sel_n = 1'b0; addr0 = a0; vin = v; rdcv = 1'b1;
    @(negedge clk);
    rdcv = 1'b0;
    @(negedge clk);
    chk("R5 busy after start", 32'(busy), 32'd1);
    n = 0;
    while (busy && n < 100) begin
      n++;
      if (disturb && n == 3) begin addr0 = ~a0; rdcv = 1'b1; end
      if (disturb && n == 5) begin
        chk("R10 no drive while busy", 32'(bus_oe), 32'd0);
        rdcv = 1'b0;
      end
      @(negedge clk);
    end
    chk(disturb ? "R11 length kept" : "R4 busy length", 32'(n), a0 ? 32'd8 : 32'd12);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk(md ? "R3 no restart held low" : "R2 no restart held low", 32'(busy), 32'd0);
    end
  endtask

  initial begin
    #(5.0 * 150000);
    n_bad++; n_chk++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    logic [11:0] v;
    logic md, a0, w, ra;
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R12 reset busy", 32'(busy), 32'd0);
    chk("R12 reset oe", 32'(bus_oe), 32'd0);

    // R1: falling rdcv without enable, and without select
    en = 1'b0; sel_n = 1'b0; rdcv = 1'b1; @(negedge clk); rdcv = 1'b0;
    @(negedge clk); @(negedge clk);
    chk("R1 no start en low", 32'(busy), 32'd0);
    en = 1'b1; sel_n = 1'b1; solo = 1'b1; rdcv = 1'b1; @(negedge clk); rdcv = 1'b0;
    @(negedge clk); @(negedge clk);
    chk("R1 no start sel high", 32'(busy), 32'd0);
    rdcv = 1'b1; @(negedge clk); @(negedge clk);
    chk("R1 no read sel high", 32'(bus_oe), 32'd0);

    // directed: full-control, full cycle, all three formats
    do_conv(1'b0, 1'b0, 12'hA5C, 1'b0);
    do_read(1'b1, 1'b0, 12'hA5C, "R7 word");
    do_read(1'b0, 1'b0, 12'hA5C, "R8 high byte");
    do_read(1'b0, 1'b1, 12'hA5C, "R9 low byte");
    do_read(1'b1, 1'b0, 12'hA5C, "R6 full result");
    // R12: drive drops one cycle after the read ends
    sel_n = 1'b1;
    chk("R12 still driven before edge", 32'(bus_oe), 32'hFFF);
    @(negedge clk);
    chk("R12 released after edge", 32'(bus_oe), 32'd0);

    // short cycle, standalone, extremes
    do_conv(1'b1, 1'b1, 12'hFFF, 1'b0);
    do_read(1'b1, 1'b0, 12'hFF0, "R6 short result max");
    do_read(1'b0, 1'b1, 12'hFF0, "R9 short low nibble zero");
    do_conv(1'b1, 1'b0, 12'h000, 1'b0);
    do_read(1'b1, 1'b0, 12'h000, "R3 standalone zero");
    do_conv(1'b0, 1'b0, 12'h800, 1'b1);
    do_read(1'b1, 1'b0, 12'h800, "R11 result kept");
    do_conv(1'b1, 1'b1, 12'h7FF, 1'b1);
    do_read(1'b1, 1'b0, 12'h7F0, "R11 short kept");

    // random mix
    for (int it = 0; it < 40; it++) begin
      v = 12'($urandom); md = 1'($urandom); a0 = 1'($urandom);
      w = 1'($urandom); ra = 1'($urandom);
      do_conv(md, a0, v, it % 5 == 0);
      do_read(w, ra, exp_res(v, a0), w ? "R7 rand" : (ra ? "R9 rand" : "R8 rand"));
      do_read(1'b1, 1'b0, exp_res(v, a0), "R6 rand");
    end

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule